// File: doc/BRIEF.md
# Counter Array Timebase and Flag Unit

This block is the shared time reference and status collector for an array of five capture/compare channels. It holds a free-running 16-bit up-counter that advances on one of three selectable event sources: a prescaled peripheral tick, the overflow pulse of a neighbouring timer, or an external count pin. The external pin passes through a synchronizer and a rate limiter, so it can advance the counter at most once every four clocks. Counting is enabled by a software run bit. It can optionally be frozen while the system idle input is high.

Software reaches the block through a byte-wide register port with a single shared address. A mode byte selects the source, idle gating, the overflow interrupt enable and a watchdog-enable level for channel 4. A control byte holds the run bit, the overflow flag and five per-channel event flags. Two further addresses expose the counter as low and high bytes. Flags are sticky: hardware events set them, and only software writes clear them. Each channel flag drives its own interrupt line.

Top module: `cta_timebase`

## Requirements
- R1: After reset, every register reads 0x00, and `ovf_irq`, `mod_irq` and `wdt_en` are all 0.
- R2: The mode byte is at address 0. Bit 7 is idle gating, bit 6 is the watchdog enable, bits 2:1 are the source select and bit 0 is the overflow interrupt enable. Bits 5:3 read 0 and ignore writes. `wdt_en` follows bit 6.
- R3: The control byte is at address 1. Bit 7 is the overflow flag, bit 6 is run, and bits 4:0 are channel flags 4..0. Bit 5 reads 0 and ignores writes. A write loads bits 7, 6 and 4:0 from the written data.
- R4: When source select is 0 or 1, the counter advances once per `tick_i` pulse. When it is 2, it advances once per `t0_ovf_i` pulse. When it is 3, it advances on accepted external edges. Pulses from unselected sources have no effect.
- R5: While run is 0, the counter holds its value.
- R6: With idle gating 1, no count occurs while `idle_i` is 1. With idle gating 0, `idle_i` has no effect.
- R7: Each rising edge of the synchronized `ext_cnt_i` is counted once when edges are spaced 4 or more clocks apart. The counter never advances more than once per 4 clocks from this source.
- R8: A counter roll from 0xFFFF to 0x0000 sets the overflow flag. Only a control write with bit 7 = 0 clears it. A write with bit 7 = 1 sets it.
- R9: `ovf_irq` equals (overflow flag AND overflow interrupt enable), delayed by one clock.
- R10: A pulse on `mod_evt_i[i]` sets channel flag i, which stays set until software clears it. `mod_irq[i]` equals flag i.
- R11: If a channel event and a control write that clears the same flag occur in the same clock, the flag ends up set.
- R12: Address 2 reads and writes counter bits 7:0, and address 3 reads and writes bits 15:8. A write takes priority over a count in the same clock.
- R13: `rd_data` is registered. It shows the register selected by `addr` one clock after `addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| idle_i | input | 1 | System idle indication |
| tick_i | input | 1 | Prescaled peripheral tick, single-cycle pulse |
| t0_ovf_i | input | 1 | Neighbouring timer overflow, single-cycle pulse |
| ext_cnt_i | input | 1 | Asynchronous external count input |
| mod_evt_i | input | 5 | Per-channel match/capture pulses |
| ovf_irq | output | 1 | Overflow interrupt |
| mod_irq | output | 5 | Per-channel interrupts |
| wdt_en | output | 1 | Watchdog enable level for channel 4 |

## Verification
The properties assume that `tick_i`, `t0_ovf_i` and `mod_evt_i` are single-cycle pulses in the clock domain, and that `wr_en` is never held across a counter-byte write and a count in a way that breaks write priority. The bench drives every synchronous input on the falling clock edge and keeps each event pulse one clock wide. The external input is the only asynchronous pin. It is exercised both with slow toggles, spaced well above the four-clock limit, and with a toggle every clock, so that the rate limiter, rather than the stimulus, bounds the count.

// File: rtl/cta_pkg.sv
package cta_pkg;
  localparam int unsigned ADDR_MODE = 0;
  localparam int unsigned ADDR_CTRL = 1;
  localparam int unsigned ADDR_CNT  = 2;

  localparam logic [1:0] SRC_T0  = 2'b10;
  localparam logic [1:0] SRC_EXT = 2'b11;

  typedef struct packed {
    logic       idle_gate;
    logic       wdt;
    logic [1:0] src;
    logic       ovf_ie;
  } mode_t;
endpackage

// File: rtl/cta_src_sel.sv
module cta_src_sel #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATE_DIV    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src,
  input  logic       tick_i,
  input  logic       t0_ovf_i,
  input  logic       ext_i,
  output logic       cnt_evt
);
  import cta_pkg::*;

  localparam int unsigned DIV_W = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;

  logic [SYNC_STAGES:0] sync_q;
  logic [DIV_W-1:0]     div_q;
  logic                 pend_q;
  logic                 rise;
  logic                 strobe;
  logic                 ext_evt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_i};
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst)         div_q <= '0;
    else if (strobe) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign strobe = (div_q == DIV_W'(RATE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (strobe) pend_q <= rise;
    else             pend_q <= pend_q | rise;
  end

  assign ext_evt = strobe & pend_q;

  always_comb begin
    unique case (src)
      SRC_T0:  cnt_evt = t0_ovf_i;
      SRC_EXT: cnt_evt = ext_evt;
      default: cnt_evt = tick_i;
    endcase
  end
endmodule

// File: rtl/cta_counter.sv
module cta_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic [CNT_W/8-1:0] wr_be,
  input  logic [7:0]         wr_byte,
  output logic [CNT_W-1:0]   count,
  output logic               wrap
);
  localparam int unsigned NBYTES = CNT_W / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (|wr_be) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_be[b]) count[b*8 +: 8] <= wr_byte;
      end
    end else if (inc) begin
      count <= count + 1'b1;
    end
  end

  assign wrap = inc & ~(|wr_be) & (&count);
endmodule

// File: rtl/cta_flags.sv
module cta_flags #(
  parameter int unsigned NMOD = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_wr,
  input  logic            wr_ovf,
  input  logic [NMOD-1:0] wr_mod,
  input  logic            hw_ovf,
  input  logic [NMOD-1:0] hw_mod,
  output logic            ovf_flag,
  output logic [NMOD-1:0] mod_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      mod_flag <= '0;
    end else begin
      ovf_flag <= (ctrl_wr ? wr_ovf : ovf_flag) | hw_ovf;
      mod_flag <= (ctrl_wr ? wr_mod : mod_flag) | hw_mod;
    end
  end
endmodule

// File: rtl/cta_timebase.sv
module cta_timebase #(
  parameter int unsigned NMOD        = 5,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATE_DIV    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              idle_i,
  input  logic              tick_i,
  input  logic              t0_ovf_i,
  input  logic              ext_cnt_i,
  input  logic [NMOD-1:0]   mod_evt_i,
  output logic              ovf_irq,
  output logic [NMOD-1:0]   mod_irq,
  output logic              wdt_en
);
  import cta_pkg::*;

  localparam int unsigned NBYTES = CNT_W / 8;

  mode_t              mode_q;
  logic               run_q;
  logic               ctrl_wr;
  logic               mode_wr;
  logic [NBYTES-1:0]  cnt_be;
  logic               cnt_wr;
  logic               src_evt;
  logic               cnt_en;
  logic [CNT_W-1:0]   count;
  logic               wrap;
  logic               ovf_flag;
  logic [NMOD-1:0]    mod_flag;
  logic [7:0]         rd_next;

  assign mode_wr = wr_en & (addr == ADDR_W'(ADDR_MODE));
  assign ctrl_wr = wr_en & (addr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      cnt_be[b] = wr_en & (addr == ADDR_W'(ADDR_CNT + b));
    end
  end
  assign cnt_wr = |cnt_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode_q.idle_gate <= wr_data[7];
        mode_q.wdt       <= wr_data[6];
        mode_q.src       <= wr_data[2:1];
        mode_q.ovf_ie    <= wr_data[0];
      end
      if (ctrl_wr) run_q <= wr_data[6];
    end
  end

  cta_src_sel #(
    .SYNC_STAGES (SYNC_STAGES),
    .RATE_DIV    (RATE_DIV)
  ) u_src (
    .clk      (clk),
    .rst      (rst),
    .src      (mode_q.src),
    .tick_i   (tick_i),
    .t0_ovf_i (t0_ovf_i),
    .ext_i    (ext_cnt_i),
    .cnt_evt  (src_evt)
  );

  assign cnt_en = src_evt & run_q & ~(mode_q.idle_gate & idle_i);

  cta_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (cnt_en),
    .wr_be   (cnt_be),
    .wr_byte (wr_data),
    .count   (count),
    .wrap    (wrap)
  );

  cta_flags #(.NMOD(NMOD)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ctrl_wr  (ctrl_wr),
    .wr_ovf   (wr_data[7]),
    .wr_mod   (wr_data[NMOD-1:0]),
    .hw_ovf   (wrap),
    .hw_mod   (mod_evt_i),
    .ovf_flag (ovf_flag),
    .mod_flag (mod_flag)
  );

  always_comb begin
    rd_next = 8'h00;
    if (addr == ADDR_W'(ADDR_MODE)) begin
      rd_next = {mode_q.idle_gate, mode_q.wdt, 3'b000, mode_q.src, mode_q.ovf_ie};
    end else if (addr == ADDR_W'(ADDR_CTRL)) begin
      rd_next[7]        = ovf_flag;
      rd_next[6]        = run_q;
      rd_next[NMOD-1:0] = mod_flag;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(ADDR_CNT + b)) rd_next = count[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
      ovf_irq <= 1'b0;
    end else begin
      rd_data <= rd_next;
      ovf_irq <= ovf_flag & mode_q.ovf_ie;
    end
  end

  assign mod_irq = mod_flag;
  assign wdt_en  = mode_q.wdt;
endmodule

// File: rtl/cta_timebase_chk.sv
module cta_timebase_chk #(
  parameter int unsigned NMOD   = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic              ctrl_wr,
  input logic              cnt_wr,
  input logic              cnt_en,
  input logic              run_q,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              ovf_ie,
  input logic              ovf_irq,
  input logic [NMOD-1:0]   mod_evt_i,
  input logic [NMOD-1:0]   mod_irq
);
  // R5
  a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr) |=> $stable(count));

  // R8
  a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !cnt_wr && (&count)) |=> ovf_flag);

  a_r8_no_hw_clear: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ctrl_wr) |=> ovf_flag);

  // R9
  a_r9_irq_on: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && ovf_ie) |=> ovf_irq);

  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(ovf_flag && ovf_ie) |=> !ovf_irq);

  // R10
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> ((mod_irq & $past(mod_irq)) == $past(mod_irq)));

  // R11
  a_r11_hw_wins: assert property (@(posedge clk) disable iff (rst)
    (|mod_evt_i) |=> ((mod_irq & $past(mod_evt_i)) == $past(mod_evt_i)));

  // R2
  a_r2_mode_reserved: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(0)) |=> (rd_data[5:3] == 3'b000));

  // R3
  a_r3_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(1)) |=> (rd_data[5] == 1'b0));
endmodule

bind cta_timebase cta_timebase_chk #(
  .NMOD   (NMOD),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .rd_data   (rd_data),
  .ctrl_wr   (ctrl_wr),
  .cnt_wr    (cnt_wr),
  .cnt_en    (cnt_en),
  .run_q     (run_q),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .ovf_ie    (mode_q.ovf_ie),
  .ovf_irq   (ovf_irq),
  .mod_evt_i (mod_evt_i),
  .mod_irq   (mod_irq)
);

// File: tb/cta_timebase_tb.sv
module cta_timebase_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       idle_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       t0_ovf_i = 1'b0;
  logic       ext_cnt_i = 1'b0;
  logic [4:0] mod_evt_i = '0;
  logic       ovf_irq;
  logic [4:0] mod_irq;
  logic       wdt_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cta_timebase u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .idle_i(idle_i), .tick_i(tick_i), .t0_ovf_i(t0_ovf_i),
    .ext_cnt_i(ext_cnt_i), .mod_evt_i(mod_evt_i), .ovf_irq(ovf_irq),
    .mod_irq(mod_irq), .wdt_en(wdt_en)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    c = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(2'd2, c[7:0]);
    wr(2'd3, c[15:8]);
  endtask

  task automatic pulse_tick(input int n);
    repeat (n) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic pulse_t0(input int n);
    repeat (n) begin
      @(negedge clk) t0_ovf_i = 1'b1;
      @(negedge clk) t0_ovf_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), {8'h0, d}, 16'h0000);
    end
    chk("R1 ovf_irq after reset", {15'h0, ovf_irq}, 16'h0);
    chk("R1 mod_irq after reset", {11'h0, mod_irq}, 16'h0);
    chk("R1 wdt_en after reset", {15'h0, wdt_en}, 16'h0);
  endtask

  task automatic t_mode;
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d);
    chk("R2 mode reserved bits", {8'h0, d}, 16'h00C7);
    chk("R2 wdt_en set", {15'h0, wdt_en}, 16'h1);
    wr(2'd0, 8'h00);
    chk("R2 wdt_en clear", {15'h0, wdt_en}, 16'h0);
    wr(2'd1, 8'h20);
    rd(2'd1, d);
    chk("R3 ctrl reserved bit", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_rd_latency;
    logic [7:0] d;
    wr(2'd0, 8'h81);
    rd(2'd0, d);
    @(negedge clk) addr = 2'd1;
    #1;
    chk("R13 old data before edge", {8'h0, rd_data}, 16'h0081);
    @(negedge clk);
    chk("R13 new data after edge", {8'h0, rd_data}, 16'h0000);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_tick_src;
    logic [15:0] c;
    wr(2'd0, 8'h00);
    set_cnt(16'h0000);
    wr(2'd1, 8'h40);
    pulse_tick(5);
    rd_cnt(c);
    chk("R4 tick source count", c, 16'd5);
    pulse_t0(3);
    rd_cnt(c);
    chk("R4 t0 ignored in tick mode", c, 16'd5);
    wr(2'd1, 8'h00);
    pulse_tick(3);
    rd_cnt(c);
    chk("R5 stopped counter holds", c, 16'd5);
  endtask

  task automatic t_idle;
    logic [15:0] c;
    wr(2'd0, 8'h80);
    set_cnt(16'h0010);
    wr(2'd1, 8'h40);
    idle_i = 1'b1;
    pulse_tick(4);
    rd_cnt(c);
    chk("R6 gated during idle", c, 16'h0010);
    idle_i = 1'b0;
    pulse_tick(2);
    rd_cnt(c);
    chk("R6 counts when not idle", c, 16'h0012);
    wr(2'd0, 8'h00);
    idle_i = 1'b1;
    pulse_tick(3);
    idle_i = 1'b0;
    rd_cnt(c);
    chk("R6 idle ignored when gating off", c, 16'h0015);
  endtask

  task automatic t_t0_src;
    logic [15:0] c;
    wr(2'd0, 8'h04);
    set_cnt(16'h0100);
    pulse_tick(2);
    pulse_t0(4);
    rd_cnt(c);
    chk("R4 t0 source count, tick ignored", c, 16'h0104);
  endtask

  task automatic t_ext;
    logic [15:0] c0, c1;
    int delta;
    wr(2'd0, 8'h06);
    set_cnt(16'h0000);
    repeat (6) begin
      @(negedge clk) ext_cnt_i = 1'b1;
      repeat (8) @(negedge clk);
      ext_cnt_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    rd_cnt(c0);
    chk("R7 slow external edges", c0, 16'd6);
    pulse_tick(3);
    rd_cnt(c0);
    chk("R4 tick ignored in external mode", c0, 16'd6);
    repeat (40) @(negedge clk) ext_cnt_i = ~ext_cnt_i;
    ext_cnt_i = 1'b0;
    repeat (10) @(negedge clk);
    rd_cnt(c1);
    delta = int'(c1 - c0);
    n_chk++;
    if (delta > 11 || delta < 5) begin
      n_fail++;
      $display("FAIL R7 rate limit: actual=%0d expected=5..11", delta);
    end
  endtask

  task automatic t_ovf;
    logic [7:0] d;
    logic [15:0] c;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h01);
    set_cnt(16'hFFFE);
    pulse_tick(1);
    rd(2'd1, d);
    chk("R8 no flag before roll", {8'h0, d}, 16'h0040);
    pulse_tick(1);
    @(negedge clk);
    chk("R9 irq after roll", {15'h0, ovf_irq}, 16'h1);
    rd(2'd1, d);
    chk("R8 flag set by roll", {8'h0, d}, 16'h00C0);
    rd_cnt(c);
    chk("R8 counter wrapped", c, 16'h0000);
    pulse_tick(2);
    rd(2'd1, d);
    chk("R8 hardware keeps flag", {8'h0, d}, 16'h00C0);
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R9 irq masked", {15'h0, ovf_irq}, 16'h0);
    wr(2'd1, 8'h40);
    rd(2'd1, d);
    chk("R8 software clear", {8'h0, d}, 16'h0040);
    wr(2'd1, 8'hC0);
    rd(2'd1, d);
    chk("R8 software set", {8'h0, d}, 16'h00C0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_mod_flags;
    @(negedge clk) mod_evt_i = 5'b00101;
    @(negedge clk) mod_evt_i = 5'b00000;
    chk("R10 flags set by pulses", {11'h0, mod_irq}, 16'h0005);
    @(negedge clk) mod_evt_i = 5'b00010;
    @(negedge clk) mod_evt_i = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R10 flags sticky and separate", {11'h0, mod_irq}, 16'h0007);
    wr(2'd1, 8'h00);
    chk("R10 software clear", {11'h0, mod_irq}, 16'h0000);
    @(negedge clk);
    addr = 2'd1; wr_data = 8'h00; wr_en = 1'b1; mod_evt_i = 5'b10000;
    @(negedge clk);
    wr_en = 1'b0; mod_evt_i = 5'b00000;
    chk("R11 hardware set beats clear", {11'h0, mod_irq}, 16'h0010);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_cnt_write;
    logic [15:0] c;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    set_cnt(16'hA55A);
    rd_cnt(c);
    chk("R12 byte write and read", c, 16'hA55A);
    @(negedge clk);
    addr = 2'd2; wr_data = 8'h33; wr_en = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_i = 1'b0;
    wr(2'd1, 8'h00);
    rd_cnt(c);
    chk("R12 write beats count", c, 16'hA533);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode();
    t_rd_latency();
    t_tick_src();
    t_idle();
    t_t0_src();
    t_ext();
    t_ovf();
    t_mod_flags();
    t_cnt_write();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule